// File: doc/BRIEF.md
# Shortened Reed-Solomon Outer Encoder (204,188)

This block adds forward error correction to a stream of scrambled transport packets. Each packet of 188 bytes enters as a byte stream. The bytes leave unchanged, and in the same cycle, while a bank of 16 parity registers divides the message polynomial by the code's generator polynomial over GF(256). After the 188th byte the block stops taking input. It then emits the 16 remainder bytes, so that every packet leaves as a 204-byte systematic codeword.

The code is a shortened form of a 255-symbol code. The 51 leading message symbols of the full-length code are taken to be zero. A zero symbol entering a cleared division register leaves it cleared, so these symbols cost no cycles and need no logic. Both sides of the block use a valid/ready handshake. Output markers flag the first and the last byte of each codeword. An input start-of-packet marker realigns the byte count.

Top module: `rs_outer_enc`

## Requirements
- R1: Each codeword has exactly 204 output transfers: 188 data bytes, then 16 parity bytes. `out_sop` is high on the first data byte of every codeword, including one whose first input byte carries no `in_sop`. `out_eop` is high only on the 16th parity byte.
- R2: In the data phase, each accepted input byte appears on `out_data` in the same cycle, unchanged, with `out_valid` equal to `in_valid`.
- R3: The parity is the remainder of m(x)·x^16 divided by g(x) = (x+a^0)(x+a^1)…(x+a^15). The message polynomial m(x) has the first data byte as its highest coefficient. Arithmetic is in GF(256) built on x^8+x^4+x^3+x^2+1 (0x11D), with a = 0x02. The parity byte sent first is the coefficient of x^15.
- R4: The block spends no cycles on the implied leading zero symbols. A packet of 188 zero bytes yields 16 zero parity bytes.
- R5: While parity bytes are being sent, `in_ready` is low and `out_valid` is high.
- R6: `in_ready` is never high while `out_ready` is low. A parity byte presented while `out_ready` is low stays unchanged on `out_data` until it is taken.
- R7: An accepted byte with `in_sop` high is byte 0 of a new packet, even in the middle of a packet. The parity of the partial packet is discarded.
- R8: After reset, the block is in the data phase at byte 0. With no input, `out_valid` is low and `in_ready` follows `out_ready`.
- R9: Idle cycles between input bytes (`in_valid` low) do not change the codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte available |
| in_ready | output | 1 | Block takes the input byte this cycle |
| in_data | input | 8 | Input packet byte |
| in_sop | input | 1 | Input byte is byte 0 of a packet |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Downstream takes the output byte this cycle |
| out_data | output | 8 | Codeword byte |
| out_sop | output | 1 | First byte of a codeword |
| out_eop | output | 1 | Last byte of a codeword |

## Verification
The assertions check on every cycle:
- that the end marker falls on output transfer 204 of a codeword;
- that input is refused after transfer 188;
- that data passes through unchanged;
- that `in_ready` never leads `out_ready`;
- that a stalled parity byte holds steady.

Only the bench's scenarios can show that the parity values are correct. It compares each parity byte with an independent long-division model, under these scenarios:
- zero packets;
- a lone trailing one, whose parity must equal the generator coefficients;
- ramp and pseudo-random data;
- gaps in the input;
- output back-pressure;
- a restart in the middle of a packet.

// File: rtl/rs_enc_pkg.sv
// Package: shared types and GF(2^8) helpers for the outer encoder.
// Assumes an 8-bit symbol; the field polynomial and root offset are passed
// in so the arithmetic can be reused with other parameter sets.
package rs_enc_pkg;

    localparam int SYM_W      = 8;
    localparam int RS_NPAR    = 16;
    localparam int RS_DLEN    = 188;
    localparam int RS_POLY    = 'h11D;
    localparam int RS_ROOT0   = 0;
    localparam int MAX_NPAR   = 63;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic {
        PH_DATA   = 1'b0,
        PH_PARITY = 1'b1
    } phase_e;

    // Field product: shift-and-add with reduction by the field polynomial.
    function automatic sym_t gf_mul(input sym_t a, input sym_t b, input int poly);
        sym_t acc;
        sym_t red;
        logic hi;
        red = sym_t'(poly);
        acc = '0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            hi  = acc[SYM_W-1];
            acc = acc << 1;
            if (hi) acc = acc ^ red;
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    // Power of the primitive element 0x02.
    function automatic sym_t gf_alpha_pow(input int e, input int poly);
        sym_t r;
        r = sym_t'(1);
        for (int i = 0; i < e; i++) r = gf_mul(r, sym_t'(2), poly);
        return r;
    endfunction

    // Coefficient k of the monic generator built from npar consecutive roots.
    function automatic sym_t gen_coef(input int k, input int npar,
                                      input int root0, input int poly);
        sym_t c [0:MAX_NPAR];
        sym_t rt;
        for (int j = 0; j <= MAX_NPAR; j++) c[j] = '0;
        c[0] = sym_t'(1);
        for (int i = 0; i < npar; i++) begin
            rt = gf_alpha_pow(root0 + i, poly);
            for (int j = MAX_NPAR; j >= 1; j--) c[j] = c[j-1] ^ gf_mul(c[j], rt, poly);
            c[0] = gf_mul(c[0], rt, poly);
        end
        return c[k];
    endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
// Module: multiplies a symbol by a fixed field constant.
// Assumes COEF is elaboration-time constant; the result is a pure XOR network.
module rs_gf_cmul
    import rs_enc_pkg::*;
#(
    parameter sym_t COEF       = sym_t'(1),
    parameter int   FIELD_POLY = RS_POLY
) (
    input  sym_t x,
    output sym_t y
);

    // Constant multiply, folded by the tool into XOR gates.
    always_comb y = gf_mul(x, COEF, FIELD_POLY);

endmodule

// File: rtl/rs_parity_lfsr.sv
// Module: parity register bank performing systematic division by g(x).
// Assumes load and shift are never high together; clear is only used
// together with load and discards the previous remainder.
module rs_parity_lfsr
    import rs_enc_pkg::*;
#(
    parameter int NPAR       = RS_NPAR,
    parameter int FIELD_POLY = RS_POLY,
    parameter int FIRST_ROOT = RS_ROOT0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    input  logic shift,
    input  sym_t din,
    output sym_t par_top
);

    sym_t par_q [NPAR];
    sym_t prod  [NPAR];
    sym_t fb;

    // Feedback symbol: incoming byte plus the current highest remainder term.
    always_comb fb = din ^ (clear ? sym_t'(0) : par_q[NPAR-1]);

    // One constant multiplier per generator coefficient.
    for (genvar g = 0; g < NPAR; g++) begin : g_tap
        rs_gf_cmul #(
            .COEF       (gen_coef(g, NPAR, FIRST_ROOT, FIELD_POLY)),
            .FIELD_POLY (FIELD_POLY)
        ) u_mul (
            .x (fb),
            .y (prod[g])
        );
    end

    // Division step on each accepted byte, or plain shift-out of the parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPAR; i++) par_q[i] <= '0;
        end else if (load) begin
            par_q[0] <= prod[0];
            for (int i = 1; i < NPAR; i++)
                par_q[i] <= (clear ? sym_t'(0) : par_q[i-1]) ^ prod[i];
        end else if (shift) begin
            par_q[0] <= '0;
            for (int i = 1; i < NPAR; i++) par_q[i] <= par_q[i-1];
        end
    end

    // The highest-order remainder term is the next parity byte to send.
    always_comb par_top = par_q[NPAR-1];

endmodule

// File: rtl/rs_seq_ctrl.sv
// Module: packet sequencer; counts data bytes, then parity bytes.
// Assumes downstream back-pressure is applied through out_ready and that
// in_sop realigns the byte count to zero when accepted.
module rs_seq_ctrl
    import rs_enc_pkg::*;
#(
    parameter int DATA_LEN = RS_DLEN,
    parameter int NPAR     = RS_NPAR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sop,
    input  logic out_ready,
    output logic in_ready,
    output logic data_phase,
    output logic load,
    output logic clear,
    output logic shift,
    output logic first_byte,
    output logic last_par
);

    localparam int CNT_W = $clog2(DATA_LEN);
    localparam int PID_W = $clog2(NPAR);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_LEN - 1);
    localparam logic [PID_W-1:0] LAST_PAR  = PID_W'(NPAR - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] byte_idx;
    logic [PID_W-1:0] pidx_q;
    logic             accept;

    // Handshake decode and per-cycle strobes for the parity bank.
    always_comb begin
        data_phase = (phase_q == PH_DATA);
        in_ready   = data_phase && out_ready;
        accept     = in_valid && in_ready;
        byte_idx   = in_sop ? '0 : cnt_q;
        load       = accept;
        clear      = accept && in_sop;
        shift      = !data_phase && out_ready;
        first_byte = data_phase && (in_sop || (cnt_q == '0));
        last_par   = !data_phase && (pidx_q == LAST_PAR);
    end

    // Phase and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            pidx_q  <= '0;
        end else if (data_phase) begin
            if (accept) begin
                if (byte_idx == LAST_DATA) begin
                    phase_q <= PH_PARITY;
                    cnt_q   <= '0;
                end else begin
                    cnt_q   <= byte_idx + 1'b1;
                end
            end
        end else if (out_ready) begin
            if (pidx_q == LAST_PAR) begin
                phase_q <= PH_DATA;
                pidx_q  <= '0;
            end else begin
                pidx_q  <= pidx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_outer_enc.sv
// Module: top of the (204,188) outer encoder.
// Assumes scrambled 188-byte packets; emits each one followed by 16 parity
// bytes, with leading zero symbols of the full-length code left implicit.
module rs_outer_enc
    import rs_enc_pkg::*;
#(
    parameter int DATA_LEN   = RS_DLEN,
    parameter int NPAR       = RS_NPAR,
    parameter int FIELD_POLY = RS_POLY,
    parameter int FIRST_ROOT = RS_ROOT0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SYM_W-1:0] in_data,
    input  logic             in_sop,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SYM_W-1:0] out_data,
    output logic             out_sop,
    output logic             out_eop
);

    logic data_phase;
    logic load;
    logic clear;
    logic shift;
    logic first_byte;
    logic last_par;
    sym_t par_top;

    rs_seq_ctrl #(
        .DATA_LEN (DATA_LEN),
        .NPAR     (NPAR)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .data_phase (data_phase),
        .load       (load),
        .clear      (clear),
        .shift      (shift),
        .first_byte (first_byte),
        .last_par   (last_par)
    );

    rs_parity_lfsr #(
        .NPAR       (NPAR),
        .FIELD_POLY (FIELD_POLY),
        .FIRST_ROOT (FIRST_ROOT)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .clear   (clear),
        .shift   (shift),
        .din     (in_data),
        .par_top (par_top)
    );

    // Output select: pass-through in the data phase, remainder afterwards.
    always_comb begin
        out_valid = data_phase ? in_valid : 1'b1;
        out_data  = data_phase ? in_data  : par_top;
        out_sop   = first_byte;
        out_eop   = last_par;
    end

endmodule

// File: rtl/rs_outer_enc_chk.sv
// Module: protocol checker for rs_outer_enc, attached with bind.
// Assumes only the top-level ports; keeps its own count of output transfers.
module rs_outer_enc_chk #(
    parameter int DATA_LEN = 188,
    parameter int NPAR     = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_sop,
    input logic       out_eop
);

    localparam int CW_LEN = DATA_LEN + NPAR;

    logic [15:0] beat_q;
    logic [15:0] beat_idx;

    // Position of the current output byte within its codeword.
    always_comb beat_idx = out_sop ? 16'd0 : beat_q;

    // Advance the position on each output transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) beat_q <= '0;
        else if (out_valid && out_ready) beat_q <= beat_idx + 16'd1;
    end

    AST_EOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_eop |-> beat_idx == 16'(CW_LEN - 1)); // R1
    AST_MARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_sop && out_eop)); // R1
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> out_valid && out_data == in_data); // R2
    AST_NO_INPUT_IN_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && beat_idx >= 16'(DATA_LEN) && beat_idx < 16'(CW_LEN) |-> !in_ready); // R5
    AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready); // R6
    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && beat_idx >= 16'(DATA_LEN) && beat_idx < 16'(CW_LEN)
        |=> out_valid && $stable(out_data)); // R6

endmodule

bind rs_outer_enc rs_outer_enc_chk #(
    .DATA_LEN (DATA_LEN),
    .NPAR     (NPAR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/tb_rs_outer_enc.sv
// Bench: scoreboard for rs_outer_enc. The driver pushes the expected bytes,
// computed by an independent long-division model, and the monitor pops them.
module tb_rs_outer_enc;

    typedef struct packed {
        logic [7:0] d;
        logic       sop;
        logic       eop;
        logic       par;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_sop = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_sop;
    logic       out_eop;

    int   errors = 0;
    int   checks = 0;
    int   rdy_mode = 0;
    int   gap_mode = 0;
    int   cyc = 0;
    logic [7:0] par_or = 8'h00;
    exp_t sb [$];
    logic [7:0] pkt [0:187];
    logic [7:0] gpoly [0:16];

    always #5 clk = ~clk;

    rs_outer_enc dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_sop    (in_sop),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = 16'h0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11D << (i - 8));
        return p[7:0];
    endfunction

    // Generator coefficients, gpoly[k] multiplies x^k, gpoly[16] = 1.
    task automatic build_gen();
        logic [7:0] rt = 8'h01;
        for (int k = 0; k <= 16; k++) gpoly[k] = 8'h00;
        gpoly[0] = 8'h01;
        for (int i = 0; i < 16; i++) begin
            for (int k = 16; k >= 1; k--) gpoly[k] = gpoly[k-1] ^ fmul(gpoly[k], rt);
            gpoly[0] = fmul(gpoly[0], rt);
            rt = fmul(rt, 8'h02);
        end
    endtask

    // Push expected output for n bytes of pkt; a full packet adds parity.
    task automatic push_expect(input int n);
        logic [7:0] w [0:203];
        exp_t e;
        for (int i = 0; i < 204; i++) w[i] = (i < n) ? pkt[i] : 8'h00;
        for (int i = 0; i < n; i++) begin
            e.d = pkt[i]; e.sop = (i == 0); e.eop = 1'b0; e.par = 1'b0;
            sb.push_back(e);
        end
        if (n == 188) begin
            for (int i = 0; i < 188; i++) begin
                logic [7:0] q = w[i];
                for (int j = 1; j <= 16; j++) w[i+j] = w[i+j] ^ fmul(q, gpoly[16-j]);
            end
            for (int i = 0; i < 16; i++) begin
                e.d = w[188+i]; e.sop = 1'b0; e.eop = (i == 15); e.par = 1'b1;
                sb.push_back(e);
            end
        end
    endtask

    // Drive n bytes of pkt; optionally flag the first with in_sop.
    task automatic send(input int n, input bit with_sop);
        push_expect(n);
        for (int i = 0; i < n; i++) begin
            if (gap_mode != 0 && (i % 3) == 1) begin
                in_valid = 1'b0;
                @(posedge clk); #2;
            end
            in_valid = 1'b1;
            in_data  = pkt[i];
            in_sop   = with_sop && (i == 0);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk); #2;
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(posedge clk);
        @(posedge clk); #2;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Output-ready pattern driver.
    initial begin
        forever begin
            @(posedge clk); #2;
            cyc++;
            out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
        end
    end

    // Monitor: compare each output transfer with the scoreboard head.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1 unexpected output", int'(out_data), 0);
                end else begin
                    e = sb[0];
                    if (e.par) begin
                        check(!in_ready, "R5 in_ready low in parity", int'(in_ready), 0);
                        if (!out_ready)
                            check(out_data == e.d, "R6 stalled parity held", int'(out_data), int'(e.d));
                    end
                    if (out_ready) begin
                        void'(sb.pop_front());
                        if (e.par) begin
                            par_or = par_or | out_data;
                            check(out_data == e.d, "R3 parity byte", int'(out_data), int'(e.d));
                        end else begin
                            check(out_data == e.d, "R2 data byte", int'(out_data), int'(e.d));
                        end
                        check(out_sop == e.sop, "R1 sop marker", int'(out_sop), int'(e.sop));
                        check(out_eop == e.eop, "R1 eop marker", int'(out_eop), int'(e.eop));
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        build_gen();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R8 in_ready follows out_ready", int'(in_ready), 1);
        @(posedge clk); #2;

        // R4: all-zero packet, zero parity
        for (int i = 0; i < 188; i++) pkt[i] = 8'h00;
        par_or = 8'h00;
        send(188, 1'b1);
        drain();
        check(par_or == 8'h00, "R4 zero packet parity", int'(par_or), 0);

        // R3: lone trailing one gives the generator coefficients
        pkt[187] = 8'h01;
        send(188, 1'b1);
        drain();

        // R3: ramp data, packet without in_sop (R1 sop still expected)
        for (int i = 0; i < 188; i++) pkt[i] = 8'(i * 7 + 3);
        send(188, 1'b0);
        drain();

        // R6 and R9: back-pressure and idle gaps on pseudo-random data
        rdy_mode = 1;
        gap_mode = 1;
        for (int i = 0; i < 188; i++) pkt[i] = 8'($urandom);
        send(188, 1'b1);
        drain();
        gap_mode = 0;
        for (int i = 0; i < 188; i++) pkt[i] = 8'hFF;
        send(188, 1'b1);
        drain();
        rdy_mode = 0;

        // R7: partial packet, then restart with in_sop
        for (int i = 0; i < 188; i++) pkt[i] = 8'(8'hA5 ^ i);
        send(50, 1'b1);
        for (int i = 0; i < 188; i++) pkt[i] = 8'(i * 13);
        send(188, 1'b1);
        drain();

        check(sb.size() == 0, "R1 all bytes emitted", sb.size(), 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule